// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block takes a three-wire serial stream (data, serial clock, load strobe) from a host and turns it into the static settings of a frequency synthesizer: a reference divide ratio, a prescaler modulus select, a phase-detector polarity flag, a monitor-output select flag, a swallow count and a main count. All three serial wires are asynchronous to the system clock. They are brought in through synchronisers and their edges are detected in the system clock domain. The serial clock shifts bits into one shared 19-bit register, with the most significant field sent first. The bit sent last is a routing tag.

On the rising edge of the load strobe, the routing tag picks one of two holding latches, and each latch takes the shared register in its own field layout. The reference ratio and the main ratio both have a floor. A word that would put either ratio below the floor is refused as a whole, and a sticky error flag is raised. Loading depends only on the system clock and reset, with no power-state input, so the host can keep programming while the synthesizer core is powered down.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset the outputs are ref_ratio=5, main_ratio=5, swallow=0, presc_sel=0, phase_pol=1, mon_sel=0 and ratio_err=0.
- R2: Each rising edge of ser_clk moves one ser_dat bit into the low end of a 19-bit shift register, and the bits already held move one place up. Only the last 19 bits sent before a load count, and the bit sent last (position 0) is the routing tag.
- R3: A load with tag 1 and a legal ratio sets ref_ratio=word[14:1], presc_sel=word[15], phase_pol=word[16] and mon_sel=word[17]. swallow and main_ratio are left unchanged.
- R4: A load with tag 0 and a legal ratio sets swallow=word[7:1] and main_ratio=word[18:8]. The four reference outputs are left unchanged.
- R5: In a word with tag 1, bit 18 has no effect on any output.
- R6: A tag-1 word whose ratio field word[14:1] is below 5 changes none of the four reference outputs, and it sets ratio_err.
- R7: A tag-0 word whose field word[18:8] is below 5 changes neither swallow nor main_ratio, and it sets ratio_err. Every swallow value from 0 to 127 is legal.
- R8: Once set, ratio_err stays at 1 until reset. Legal loads made after it is set still take effect.
- R9: Latching happens only on a rising edge of ser_le. If ser_le is held high while further bits are shifted in, no output changes until the next rising edge of ser_le.
- R10: The outputs take a load's values on the third rising edge of clk after ser_le rises, and still hold the old values after the second rising edge. ser_clk and ser_le must hold each level for at least 3 clk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, most significant field first |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| ref_ratio | output | 14 | Latched reference divide ratio |
| presc_sel | output | 1 | Prescaler select (1 = small modulus pair) |
| phase_pol | output | 1 | Phase-detector polarity flag |
| mon_sel | output | 1 | Monitor-output select flag |
| swallow | output | 7 | Latched swallow count |
| main_ratio | output | 11 | Latched main divide ratio |
| ratio_err | output | 1 | Sticky flag for a refused ratio |

## Verification
Every serial input passes through a two-stage synchroniser followed by an edge-detect register, so a bit or a load takes effect three clk rising edges after its wire rises. The bench changes the inputs on falling clock edges and holds each serial level for four cycles. For every load it samples the outputs after the second rising edge, where they must still hold the old values, and again after the third, where they must hold the new ones. Between loads it also checks the outputs while ser_le is held high and more bits are shifted in.

// File: rtl/sld_pkg.sv
package sld_pkg;
   localparam int DEF_REF_W    = 14;
   localparam int DEF_SWAL_W   = 7;
   localparam int DEF_MAIN_W   = 11;
   localparam int DEF_MIN      = 5;
   localparam int DEF_SYNC     = 2;

   typedef enum logic {
      ROUTE_DIV = 1'b0,
      ROUTE_REF = 1'b1
   } route_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sld_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sld_shift_reg.sv
module sld_shift_reg #(
   parameter int WIDTH = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             bit_in,
   output logic [WIDTH-1:0] word
);
   generate
      if (WIDTH < 2) begin : g_bad
         $error("sld_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WIDTH-2:0], bit_in};
   end
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank
   import sld_pkg::*;
#(
   parameter int REF_W       = DEF_REF_W,
   parameter int SWAL_W      = DEF_SWAL_W,
   parameter int MAIN_W      = DEF_MAIN_W,
   parameter int MIN_RATIO   = DEF_MIN,
   parameter bit RANGE_CHECK = 1'b1,
   parameter int SR_W        = 1 + imax(REF_W + 3, SWAL_W + MAIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SR_W-1:0]   word,
   output logic [REF_W-1:0]  ref_ratio,
   output logic              presc_sel,
   output logic              phase_pol,
   output logic              mon_sel,
   output logic [SWAL_W-1:0] swallow,
   output logic [MAIN_W-1:0] main_ratio,
   output logic              ratio_err
);
   localparam int SW_POS  = REF_W + 1;
   localparam int FC_POS  = REF_W + 2;
   localparam int MON_POS = REF_W + 3;
   localparam int N_LO    = SWAL_W + 1;

   generate
      if (MON_POS > SR_W - 1 || N_LO + MAIN_W > SR_W) begin : g_bad
         $error("sld_latch_bank: SR_W too small for field layout");
      end
   endgenerate

   route_e              tag;
   logic [REF_W-1:0]    r_new;
   logic [SWAL_W-1:0]   a_new;
   logic [MAIN_W-1:0]   n_new;
   logic                r_ok;
   logic                n_ok;

   assign tag   = route_e'(word[0]);
   assign r_new = word[REF_W:1];
   assign a_new = word[SWAL_W:1];
   assign n_new = word[N_LO +: MAIN_W];

   generate
      if (RANGE_CHECK) begin : g_floor
         assign r_ok = (r_new >= REF_W'(MIN_RATIO));
         assign n_ok = (n_new >= MAIN_W'(MIN_RATIO));
      end else begin : g_nofloor
         assign r_ok = 1'b1;
         assign n_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_ratio  <= REF_W'(MIN_RATIO);
         presc_sel  <= 1'b0;
         phase_pol  <= 1'b1;
         mon_sel    <= 1'b0;
         swallow    <= '0;
         main_ratio <= MAIN_W'(MIN_RATIO);
         ratio_err  <= 1'b0;
      end else if (load) begin
         if (tag == ROUTE_REF) begin
            if (r_ok) begin
               ref_ratio <= r_new;
               presc_sel <= word[SW_POS];
               phase_pol <= word[FC_POS];
               mon_sel   <= word[MON_POS];
            end else begin
               ratio_err <= 1'b1;
            end
         end else begin
            if (n_ok) begin
               swallow    <= a_new;
               main_ratio <= n_new;
            end else begin
               ratio_err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
   import sld_pkg::*;
#(
   parameter int REF_W       = DEF_REF_W,
   parameter int SWAL_W      = DEF_SWAL_W,
   parameter int MAIN_W      = DEF_MAIN_W,
   parameter int MIN_RATIO   = DEF_MIN,
   parameter int SYNC_STAGES = DEF_SYNC,
   parameter bit RANGE_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_le,
   output logic [REF_W-1:0]  ref_ratio,
   output logic              presc_sel,
   output logic              phase_pol,
   output logic              mon_sel,
   output logic [SWAL_W-1:0] swallow,
   output logic [MAIN_W-1:0] main_ratio,
   output logic              ratio_err
);
   localparam int SR_W   = 1 + imax(REF_W + 3, SWAL_W + MAIN_W);
   localparam int N_WIRE = 3;

   generate
      if (MIN_RATIO < 1 || MIN_RATIO >= (1 << MAIN_W)) begin : g_bad_min
         $error("synth_serial_loader: MIN_RATIO out of range");
      end
   endgenerate

   logic [N_WIRE-1:0] raw_in;
   logic [N_WIRE-1:0] syn;
   assign raw_in = {ser_le, ser_clk, ser_dat};

   generate
      for (genvar gi = 0; gi < N_WIRE; gi++) begin : g_sync
         sld_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[gi]),
            .dout (syn[gi])
         );
      end
   endgenerate

   logic dat_s, sck_s, le_s;
   assign dat_s = syn[0];
   assign sck_s = syn[1];
   assign le_s  = syn[2];

   logic sck_prev, le_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0;
         le_prev  <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         le_prev  <= le_s;
      end
   end

   logic sck_rise, le_rise;
   assign sck_rise = sck_s & ~sck_prev;
   assign le_rise  = le_s & ~le_prev;

   logic [SR_W-1:0] sr_word;

   sld_shift_reg #(.WIDTH(SR_W)) u_sr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(sck_rise),
      .bit_in  (dat_s),
      .word    (sr_word)
   );

   sld_latch_bank #(
      .REF_W      (REF_W),
      .SWAL_W     (SWAL_W),
      .MAIN_W     (MAIN_W),
      .MIN_RATIO  (MIN_RATIO),
      .RANGE_CHECK(RANGE_CHECK),
      .SR_W       (SR_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (le_rise),
      .word      (sr_word),
      .ref_ratio (ref_ratio),
      .presc_sel (presc_sel),
      .phase_pol (phase_pol),
      .mon_sel   (mon_sel),
      .swallow   (swallow),
      .main_ratio(main_ratio),
      .ratio_err (ratio_err)
   );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
   parameter int REF_W       = 14,
   parameter int SWAL_W      = 7,
   parameter int MAIN_W      = 11,
   parameter int MIN_RATIO   = 5,
   parameter bit RANGE_CHECK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_stb,
   input logic              tag,
   input logic [REF_W-1:0]  ref_ratio,
   input logic              presc_sel,
   input logic              phase_pol,
   input logic              mon_sel,
   input logic [SWAL_W-1:0] swallow,
   input logic [MAIN_W-1:0] main_ratio,
   input logic              ratio_err
);
   logic [REF_W+2:0]         ref_bus;
   logic [SWAL_W+MAIN_W-1:0] div_bus;
   assign ref_bus = {ref_ratio, presc_sel, phase_pol, mon_sel};
   assign div_bus = {swallow, main_ratio};

   AST_REF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!RANGE_CHECK) || (ref_ratio >= REF_W'(MIN_RATIO))); // R6

   AST_MAIN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (!RANGE_CHECK) || (main_ratio >= MAIN_W'(MIN_RATIO))); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_err |=> ratio_err); // R8

   AST_ERR_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ratio_err) |-> $past(load_stb)); // R6

   AST_QUIET_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb |=> ($stable(ref_bus) && $stable(div_bus))); // R9

   AST_REF_LOAD_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && tag) |=> $stable(div_bus)); // R3

   AST_DIV_LOAD_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && !tag) |=> $stable(ref_bus)); // R4
endmodule

bind synth_serial_loader sld_checker #(
   .REF_W      (REF_W),
   .SWAL_W     (SWAL_W),
   .MAIN_W     (MAIN_W),
   .MIN_RATIO  (MIN_RATIO),
   .RANGE_CHECK(RANGE_CHECK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_stb  (le_rise),
   .tag       (sr_word[0]),
   .ref_ratio (ref_ratio),
   .presc_sel (presc_sel),
   .phase_pol (phase_pol),
   .mon_sel   (mon_sel),
   .swallow   (swallow),
   .main_ratio(main_ratio),
   .ratio_err (ratio_err)
);

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_dat = 1'b0;
   logic ser_le = 1'b0;
   logic [13:0] ref_ratio;
   logic        presc_sel, phase_pol, mon_sel;
   logic [6:0]  swallow;
   logic [10:0] main_ratio;
   logic        ratio_err;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [13:0] e_ref;
   logic        e_sw, e_fc, e_mon, e_err;
   logic [6:0]  e_a;
   logic [10:0] e_n;

   always #2 clk = ~clk;

   synth_serial_loader u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .ref_ratio(ref_ratio), .presc_sel(presc_sel),
      .phase_pol(phase_pol), .mon_sel(mon_sel), .swallow(swallow),
      .main_ratio(main_ratio), .ratio_err(ratio_err)
   );

   function automatic logic [35:0] act_vec();
      return {ref_ratio, presc_sel, phase_pol, mon_sel, swallow, main_ratio, ratio_err};
   endfunction

   function automatic logic [35:0] exp_vec();
      return {e_ref, e_sw, e_fc, e_mon, e_a, e_n, e_err};
   endfunction

   task automatic cmp(input string req);
      n_vec++;
      if (act_vec() !== exp_vec()) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act_vec(), exp_vec());
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bits(input logic [18:0] w, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_dat = w[i];
         wait_n(4);
         ser_clk = 1'b1;
         wait_n(4);
         ser_clk = 1'b0;
      end
      wait_n(4);
   endtask

   // Apply the word's effect on the model (tag = w[0]).
   task automatic model_load(input logic [18:0] w);
      if (w[0]) begin
         if (w[14:1] >= 14'd5) begin
            e_ref = w[14:1]; e_sw = w[15]; e_fc = w[16]; e_mon = w[17];
         end else e_err = 1'b1;
      end else begin
         if (w[18:8] >= 11'd5) begin
            e_a = w[7:1]; e_n = w[18:8];
         end else e_err = 1'b1;
      end
   endtask

   // Raise ser_le, check old values after 2 edges (R10), new after 3.
   task automatic strobe(input logic [18:0] w, input string req);
      ser_le = 1'b1;
      wait_n(2);
      cmp("R10 old values held after second edge");
      model_load(w);
      wait_n(1);
      cmp(req);
      wait_n(3);
      ser_le = 1'b0;
      wait_n(4);
   endtask

   task automatic load_ref(input logic [13:0] r, input logic sw, input logic fc,
                           input logic mon, input logic top, input string req);
      logic [18:0] w;
      w = {top, mon, fc, sw, r, 1'b1};
      send_bits(w, 19);
      strobe(w, req);
   endtask

   task automatic load_div(input logic [10:0] n, input logic [6:0] a, input string req);
      logic [18:0] w;
      w = {n, a, 1'b0};
      send_bits(w, 19);
      strobe(w, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int r_list[9];
      int n_list[8];
      int a_list[5];
      r_list = '{5, 6, 7, 4, 0, 1000, 16383, 8191, 3};
      n_list = '{5, 6, 2047, 4, 0, 300, 1024, 1};
      a_list = '{0, 1, 64, 126, 127};
      e_ref = 14'd5; e_sw = 1'b0; e_fc = 1'b1; e_mon = 1'b0;
      e_a = 7'd0; e_n = 11'd5; e_err = 1'b0;

      wait_n(4);
      cmp("R1 reset values while in reset");
      rst_n = 1'b1;
      wait_n(4);
      cmp("R1 reset values after release");

      // R3 / R6: reference word sweep over ratios and all flag combinations
      for (int i = 0; i < 9; i++) begin
         for (int f = 0; f < 8; f++) begin
            load_ref(14'(r_list[i]), f[0], f[1], f[2], 1'b0,
                     (r_list[i] >= 5) ? "R3 reference load" : "R6 reference ratio refused");
         end
      end

      // R4 / R7: divider word sweep
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 5; j++) begin
            load_div(11'(n_list[i]), 7'(a_list[j]),
                     (n_list[i] >= 5) ? "R4 divider load" : "R7 main ratio refused");
         end
      end

      // R8: error flag stays set, legal loads still land
      load_ref(14'd777, 1'b1, 1'b0, 1'b1, 1'b0, "R8 legal reference after error");
      load_div(11'd99, 7'd33, "R8 legal divider after error");

      // R5: top bit of a reference word has no effect
      load_ref(14'd1234, 1'b0, 1'b1, 1'b0, 1'b1, "R5 top bit set ignored");
      load_ref(14'd1234, 1'b0, 1'b1, 1'b0, 1'b0, "R5 top bit clear same result");

      // R2: extra leading bits fall off the top; only the last 19 count
      send_bits(19'h7ffff, 7);
      begin
         logic [18:0] w;
         w = {11'd400, 7'd5, 1'b0};
         send_bits(w, 19);
         strobe(w, "R2 last 19 bits only");
      end

      // R9: le held high while shifting does not latch
      begin
         logic [18:0] w1, w2;
         w1 = {1'b0, 1'b1, 1'b1, 1'b1, 14'd4321, 1'b1};
         w2 = {1'b0, 1'b0, 1'b0, 1'b0, 14'd55, 1'b1};
         send_bits(w1, 19);
         ser_le = 1'b1;
         wait_n(3);
         model_load(w1);
         cmp("R9 first word latched on rise");
         send_bits(w2, 19);
         cmp("R9 no latch while le held high");
         ser_le = 1'b0;
         wait_n(6);
         cmp("R9 no latch on le fall");
         strobe(w2, "R9 next rise latches");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule